// File: doc/BRIEF.md
# Descriptor-Ring DMA Channel

This block is one DMA channel that a processor sets up through a small word-addressed register file. The channel reads 16-byte descriptors from memory and then copies data between memory and a device. Each descriptor gives a byte count, a source address, a destination address and the address of the next descriptor. The channel moves the bytes of one descriptor as 32-bit words, one read followed by one write per word. It counts them off in bursts of a programmed size. When the count is exhausted, it follows the next pointer on its own. A ring of descriptors whose last entry points back to the first therefore gives an endless cyclic stream, such as an audio playback or capture buffer. The per-descriptor completion flag lets software track which period has finished.

Software starts the channel in three steps. It writes the first descriptor address into the next-pointer register. It sets the fetch command bit, and it sets the enable bit. Clearing the enable bit pauses the channel at a word boundary, and setting it again continues from the same place. Writing the abort bit together with a cleared enable bit stops the channel outright. One memory port carries both the descriptor traffic and the data traffic. It uses a request/acknowledge handshake with one request outstanding at a time.

Top module: `dma_ring_chan`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and `mem_req` is 0. The register offsets are:
  - byte count at 0x00
  - source address at 0x10
  - destination address at 0x20
  - next-descriptor pointer at 0x30
  - control at 0x40
  - current-descriptor pointer at 0x70 (read-only)
  - interrupt mask at 0x80 (bit 0)
  - interrupt status at 0xA0 (bit 0)

  Writable address registers read back the value written.
- R2: Setting control bit 13 latches a fetch request, and bit 13 reads back as 1 while the request is pending. While control bit 12 (enable) is 1, a pending request makes the channel do three things. It copies the next pointer, with its low 4 bits forced to 0, into the current-descriptor register. It reads the four words at that address in the order count, source, destination, next. It then loads those words into the matching registers.
- R3: Each data word is read from the source address and then written unchanged to the destination address. After each word, the source and destination registers step according to their direction fields. The source field is control bits 3:2 and the destination field is bits 5:4. A field value of 2 holds the address; any other value adds 4.
- R4: Control bits 8:6 select the burst size: 0 gives 4 bytes, 1 gives 8, 3 gives 16, 6 gives 32, 7 gives 64 and 5 gives 128 (2 and 4 give 4). The byte-count register drops by one burst at the end of each burst, and drops to 0 at the end of a shorter final burst.
- R5: While enable is 0, the channel finishes any request already in flight and then issues no new request. Control bit 14 reads 0 while enable is 0. Setting enable again continues with the next word, with no word skipped or repeated.
- R6: A control write with bit 20 set and bit 12 clear has three effects. It drops any outstanding request in the next cycle. It returns the channel to idle with bit 14 reading 0. It cancels a pending fetch request.
- R7: When a descriptor's count reaches 0, the channel sets status bit 0. It also loads the current-descriptor register with the aligned next pointer and fetches that descriptor at once, so a ring of descriptors repeats indefinitely.
- R8: `irq` is status bit 0 AND mask bit 0. Writing 0 to status bit 0 clears it; writing 1 leaves it unchanged.
- R9: A byte count above 65536 is stored as 65536, whether it is written by software or loaded from a descriptor. A descriptor with count 0 completes without any data traffic.
- R10: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ack` is seen, unless an abort intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory response; completes the pending request |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| irq | output | 1 | Completion interrupt |

## Verification
The bench feeds several kinds of descriptors:
- A two-entry ring, which shows that the channel wraps from the last descriptor back to the first.
- A paused and resumed stream, which shows that no word is lost or repeated across the pause.
- Random single descriptors followed by an empty self-looping descriptor. These draw the burst code, count, base addresses and the hold or increment choice for each side at random. Comparing the exact address and data of every write separates a correct hold from a correct increment, and a partial last burst from a full one.

Directed cases cover three further points. The byte-count and address registers are read while the channel is paused, which pins the per-burst decrement. Over-range counts check the clamp. Aborts are issued both mid-stream and against a pending fetch.

// File: rtl/dma_ring_chan.sv
module dma_ring_chan #(
  parameter int MAX_BYTES = 65536
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        irq
);
  localparam int CNT_W = $clog2(MAX_BYTES + 1);
  localparam logic [31:0] MAX_W = 32'(MAX_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_DESC, S_RD, S_WR} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      src, dst, nxt, cur, ctrl, dbuf;
  logic [1:0]       dk;
  logic [7:0]       bb, bsz;
  logic             pend, mask, stat, req;

  function automatic logic [CNT_W-1:0] clamp_cnt(input logic [31:0] v);
    return (v > MAX_W) ? CNT_W'(MAX_BYTES) : v[CNT_W-1:0];
  endfunction

  wire              en        = ctrl[12];
  wire              active    = (st != S_IDLE) && en;
  wire              abort     = reg_we && (reg_addr == 8'h40) && reg_wdata[20] && !reg_wdata[12];
  wire [31:0]       src_step  = (ctrl[3:2] == 2'd2) ? 32'd0 : 32'd4;
  wire [31:0]       dst_step  = (ctrl[5:4] == 2'd2) ? 32'd0 : 32'd4;
  wire [7:0]        bb_n      = bb + 8'd4;
  wire [CNT_W-1:0]  bb_x      = CNT_W'(bb_n);
  wire              last      = bb_x >= cnt;
  wire              burst_end = last || (bb_n == bsz);
  wire [31:0]       next_al   = {nxt[31:4], 4'b0};

  always_comb begin
    case (ctrl[8:6])
      3'd1:    bsz = 8'd8;
      3'd3:    bsz = 8'd16;
      3'd6:    bsz = 8'd32;
      3'd7:    bsz = 8'd64;
      3'd5:    bsz = 8'd128;
      default: bsz = 8'd4;
    endcase
  end

  assign mem_req   = req;
  assign mem_we    = (st == S_WR);
  assign mem_wdata = dbuf;
  assign irq       = stat & mask;

  always_comb begin
    case (st)
      S_DESC:  mem_addr = cur + {28'b0, dk, 2'b0};
      S_RD:    mem_addr = src;
      default: mem_addr = dst;
    endcase
  end

  always_comb begin
    case (reg_addr)
      8'h00:   reg_rdata = 32'(cnt);
      8'h10:   reg_rdata = src;
      8'h20:   reg_rdata = dst;
      8'h30:   reg_rdata = nxt;
      8'h40:   reg_rdata = {ctrl[31:15], active, pend, ctrl[12:0]};
      8'h70:   reg_rdata = cur;
      8'h80:   reg_rdata = {31'b0, mask};
      8'hA0:   reg_rdata = {31'b0, stat};
      default: reg_rdata = 32'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      src  <= '0;
      dst  <= '0;
      nxt  <= '0;
      cur  <= '0;
      ctrl <= '0;
      dbuf <= '0;
      dk   <= '0;
      bb   <= '0;
      pend <= 1'b0;
      mask <= 1'b0;
      stat <= 1'b0;
      req  <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          8'h00: cnt <= clamp_cnt(reg_wdata);
          8'h10: src <= reg_wdata;
          8'h20: dst <= reg_wdata;
          8'h30: nxt <= reg_wdata;
          8'h40: begin
            ctrl <= reg_wdata;
            if (reg_wdata[13]) pend <= 1'b1;
          end
          8'h80: mask <= reg_wdata[0];
          8'hA0: if (!reg_wdata[0]) stat <= 1'b0;
          default: ;
        endcase
      end

      if (st == S_IDLE) begin
        if (pend && en) begin
          st   <= S_DESC;
          dk   <= '0;
          cur  <= next_al;
          pend <= 1'b0;
        end
      end else if (req && mem_ack) begin
        req <= 1'b0;
        case (st)
          S_DESC: begin
            dk <= dk + 2'd1;
            case (dk)
              2'd0: cnt <= clamp_cnt(mem_rdata);
              2'd1: src <= mem_rdata;
              2'd2: dst <= mem_rdata;
              default: begin
                nxt <= mem_rdata;
                if (cnt == '0) begin
                  stat <= 1'b1;
                  cur  <= {mem_rdata[31:4], 4'b0};
                end else begin
                  st <= S_RD;
                  bb <= '0;
                end
              end
            endcase
          end
          S_RD: begin
            dbuf <= mem_rdata;
            st   <= S_WR;
          end
          default: begin
            src <= src + src_step;
            dst <= dst + dst_step;
            if (burst_end) begin
              bb  <= '0;
              cnt <= last ? '0 : cnt - bb_x;
            end else begin
              bb <= bb_n;
            end
            if (last) begin
              stat <= 1'b1;
              cur  <= next_al;
              st   <= S_DESC;
              dk   <= '0;
            end else begin
              st <= S_RD;
            end
          end
        endcase
      end else if (!req && en) begin
        req <= 1'b1;
      end

      if (abort) begin
        st   <= S_IDLE;
        req  <= 1'b0;
        pend <= 1'b0;
        dk   <= '0;
        bb   <= '0;
      end
    end
  end
endmodule

module dma_ring_chan_chk #(
  parameter int MAX_BYTES = 65536
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           reg_we,
  input logic [7:0]                     reg_addr,
  input logic [31:0]                    reg_wdata,
  input logic                           mem_req,
  input logic                           mem_we,
  input logic [31:0]                    mem_addr,
  input logic [31:0]                    mem_wdata,
  input logic                           mem_ack,
  input logic                           en,
  input logic [$clog2(MAX_BYTES+1)-1:0] cnt
);
  localparam int CNT_W = $clog2(MAX_BYTES + 1);

  wire abort_w = reg_we && (reg_addr == 8'h40) && reg_wdata[20] && !reg_wdata[12];

  p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !reg_we) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_pause_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !mem_req) |=> !mem_req);

  p_abort_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_w |=> !mem_req);

  p_cnt_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_BYTES));
endmodule

bind dma_ring_chan dma_ring_chan_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .en(ctrl[12]), .cnt(cnt)
);

// File: tb/dma_ring_chan_bench.sv
module dma_ring_chan_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = 32'h0;
  logic        irq;

  logic [31:0] mem [0:4095];
  logic [31:0] log_a [0:4095];
  logic [31:0] log_d [0:4095];
  logic [31:0] exp_a [0:4095];
  logic [31:0] exp_d [0:4095];
  int nlog = 0;
  int nexp = 0;
  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  dma_ring_chan u_dma_ring_chan (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[13:2]];
      if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
    end else begin
      mem_ack <= 1'b0;
    end
    if (mem_req && mem_ack && mem_we && nlog < 4096) begin
      log_a[nlog] <= mem_addr;
      log_d[nlog] <= mem_wdata;
      nlog <= nlog + 1;
    end
  end

  function automatic logic [31:0] init_word(input int idx);
    return (32'(idx) * 32'h9E3779B1) ^ 32'h0BADF00D;
  endfunction

  function automatic logic [31:0] cw(input bit en, input bit fe, input bit ab,
                                     input logic [2:0] bc, input bit sh, input bit dh);
    return (32'(en) << 12) | (32'(fe) << 13) | (32'(ab) << 20) | (32'(bc) << 6)
         | ((dh ? 32'd2 : 32'd0) << 4) | ((sh ? 32'd2 : 32'd0) << 2);
  endfunction

  function automatic logic [2:0] bcode(input int k);
    case (k)
      0: return 3'd0;
      1: return 3'd1;
      2: return 3'd3;
      3: return 3'd6;
      4: return 3'd7;
      default: return 3'd5;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic put_desc(input int at, input logic [31:0] c, input logic [31:0] s,
                          input logic [31:0] d, input logic [31:0] n);
    mem[at/4]     = c;
    mem[at/4 + 1] = s;
    mem[at/4 + 2] = d;
    mem[at/4 + 3] = n;
  endtask

  task automatic add_exp(input logic [31:0] s, input logic [31:0] d, input int c,
                         input bit sh, input bit dh);
    for (int i = 0; i < c/4; i++) begin
      exp_a[nexp] = d + (dh ? 32'd0 : 32'(4*i));
      exp_d[nexp] = init_word(int'(((s + (sh ? 32'd0 : 32'(4*i))) >> 2) & 32'hFFF));
      nexp++;
    end
  endtask

  task automatic cmp_log(input int base, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      chk({tag, " write address"}, log_a[base+i], exp_a[i]);
      chk({tag, " write data"}, log_d[base+i], exp_d[i]);
    end
  endtask

  task automatic wait_log(input int target);
    for (int k = 0; k < 20000 && nlog < target; k++) @(negedge clk);
  endtask

  task automatic wait_stat(input string tag);
    logic [31:0] d;
    d = 32'h0;
    for (int k = 0; k < 20000; k++) begin
      rd(8'hA0, d);
      if (d[0]) break;
    end
    chk({tag, " completion status"}, d, 32'h1);
  endtask

  task automatic idle_cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int base, w, cur_nlog;
    bit quiet;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4096; i++) mem[i] = init_word(i);

    idle_cycles(4);
    rst_n = 1'b1;
    idle_cycles(2);

    // R1: reset state
    begin
      logic [7:0] offs [8] = '{8'h00, 8'h10, 8'h20, 8'h30, 8'h40, 8'h70, 8'h80, 8'hA0};
      for (int i = 0; i < 8; i++) begin
        rd(offs[i], d);
        chk("R1 reset register", d, 32'h0);
      end
    end
    chk("R1 reset irq", 32'(irq), 32'h0);
    chk("R1 reset mem_req", 32'(mem_req), 32'h0);
    wr(8'h10, 32'h1234_5678);
    rd(8'h10, d);
    chk("R1 source readback", d, 32'h1234_5678);
    wr(8'h00, 32'h40);
    rd(8'h00, d);
    chk("R1 count readback", d, 32'h40);
    wr(8'h00, 32'h000F_FFFF);
    rd(8'h00, d);
    chk("R9 count clamp on write", d, 32'h0001_0000);

    // R2 R3 R5 R7 R8: two-entry ring, paused and resumed
    put_desc(32'h000, 32'd16, 32'h400, 32'h2000, 32'h010);
    put_desc(32'h010, 32'd24, 32'h800, 32'h2100, 32'h000);
    nexp = 0;
    for (int r = 0; r < 4; r++) begin
      add_exp(32'h400, 32'h2000, 16, 1'b0, 1'b0);
      add_exp(32'h800, 32'h2100, 24, 1'b0, 1'b0);
    end
    base = nlog;
    wr(8'h80, 32'h1);
    wr(8'h30, 32'h0000_0008);
    wr(8'h40, cw(1, 1, 0, 3'd0, 0, 0));
    wait_log(base + 14);
    wr(8'h40, cw(0, 0, 0, 3'd0, 0, 0));
    idle_cycles(20);
    chk("R5 no request while paused", 32'(mem_req), 32'h0);
    rd(8'h40, d);
    chk("R5 active bit while paused", 32'(d[14]), 32'h0);
    cur_nlog = nlog;
    quiet = 1'b1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (mem_req) quiet = 1'b0;
    end
    chk("R5 paused quiet", 32'(quiet), 32'h1);
    chk("R5 paused write count", 32'(nlog), 32'(cur_nlog));
    rd(8'hA0, d);
    chk("R7 completion status set", d, 32'h1);
    chk("R8 irq with mask", 32'(irq), 32'h1);
    wr(8'h80, 32'h0);
    @(negedge clk);
    chk("R8 irq masked", 32'(irq), 32'h0);
    wr(8'h80, 32'h1);
    wr(8'hA0, 32'h1);
    rd(8'hA0, d);
    chk("R8 write one keeps status", d, 32'h1);
    wr(8'hA0, 32'h0);
    rd(8'hA0, d);
    chk("R8 write zero clears status", d, 32'h0);
    chk("R8 irq low after clear", 32'(irq), 32'h0);
    wr(8'hA0, 32'h1);
    rd(8'hA0, d);
    chk("R8 write one does not set", d, 32'h0);
    wr(8'h40, cw(1, 0, 0, 3'd0, 0, 0));
    rd(8'h40, d);
    chk("R5 active bit after resume", 32'(d[14:12]), 32'h5);
    wait_log(base + 24);
    cmp_log(base, 24, "R7 R3 ring order across pause");
    rd(8'hA0, d);
    chk("R7 status after resumed completions", d, 32'h1);

    // R6: abort mid-stream
    wr(8'h40, cw(0, 0, 1, 3'd0, 0, 0));
    chk("R6 request dropped after abort", 32'(mem_req), 32'h0);
    rd(8'h40, d);
    chk("R6 active bit after abort", 32'(d[14]), 32'h0);
    cur_nlog = nlog;
    idle_cycles(30);
    chk("R6 no writes after abort", 32'(nlog), 32'(cur_nlog));
    wr(8'h40, cw(0, 1, 0, 3'd0, 0, 0));
    rd(8'h40, d);
    chk("R2 fetch pending readback", 32'(d[14:12]), 32'h2);
    wr(8'h40, cw(0, 0, 1, 3'd0, 0, 0));
    rd(8'h40, d);
    chk("R6 abort clears pending fetch", 32'(d[14:12]), 32'h0);
    wr(8'h40, cw(1, 0, 0, 3'd0, 0, 0));
    quiet = 1'b1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (mem_req) quiet = 1'b0;
    end
    chk("R6 cancelled fetch stays idle", 32'(quiet), 32'h1);
    wr(8'h40, cw(0, 0, 1, 3'd0, 0, 0));
    wr(8'hA0, 32'h0);

    // R4: count drops per 8-byte burst, addresses advance per word
    put_desc(32'h020, 32'd64, 32'h1000, 32'h2400, 32'h030);
    put_desc(32'h030, 32'd0, 32'h0, 32'h0, 32'h030);
    nexp = 0;
    add_exp(32'h1000, 32'h2400, 64, 1'b0, 1'b0);
    base = nlog;
    wr(8'h30, 32'h020);
    wr(8'h40, cw(1, 1, 0, 3'd1, 0, 0));
    wait_log(base + 5);
    wr(8'h40, cw(0, 0, 0, 3'd1, 0, 0));
    idle_cycles(20);
    w = nlog - base;
    rd(8'h00, d);
    chk("R4 count after bursts", d, 32'(64 - 8 * (w / 2)));
    rd(8'h10, d);
    chk("R3 source progress", d, 32'h1000 + 32'(4 * w));
    rd(8'h20, d);
    chk("R3 destination progress", d, 32'h2400 + 32'(4 * w));
    rd(8'h70, d);
    chk("R2 current descriptor", d, 32'h020);
    wr(8'h40, cw(1, 0, 0, 3'd1, 0, 0));
    wait_stat("R7 burst run");
    wr(8'h40, cw(0, 0, 1, 3'd1, 0, 0));
    chk("R4 write count", 32'(nlog - base), 32'd16);
    cmp_log(base, 16, "R4 burst run data");
    rd(8'h70, d);
    chk("R7 current follows next", d, 32'h030);
    rd(8'h00, d);
    chk("R9 zero-count descriptor loaded", d, 32'h0);
    wr(8'hA0, 32'h0);

    // R9: descriptor count above the limit
    put_desc(32'h040, 32'h0003_0000, 32'h400, 32'h3000, 32'h040);
    base = nlog;
    wr(8'h30, 32'h040);
    wr(8'h40, cw(1, 1, 0, 3'd5, 0, 0));
    wait_log(base + 3);
    wr(8'h40, cw(0, 0, 0, 3'd5, 0, 0));
    idle_cycles(20);
    rd(8'h00, d);
    chk("R9 descriptor count clamped", d, 32'h0001_0000);
    wr(8'h40, cw(0, 0, 1, 3'd5, 0, 0));
    wr(8'hA0, 32'h0);

    // R3 R4 R9: random descriptors followed by an empty self-loop
    for (int it = 0; it < 20; it++) begin
      int c;
      logic [31:0] s, dd;
      bit sh, dh;
      logic [2:0] bc;
      c  = 4 * int'($urandom_range(1, 64));
      s  = 32'h400 + 32'(4 * $urandom_range(0, 1536));
      dd = 32'h2000 + 32'(4 * $urandom_range(0, 1900));
      sh = 1'($urandom_range(0, 1));
      dh = 1'($urandom_range(0, 1));
      bc = bcode(int'($urandom_range(0, 5)));
      put_desc(32'h100, 32'(c), s, dd, 32'h110);
      put_desc(32'h110, 32'd0, 32'h0, 32'h0, 32'h110);
      nexp = 0;
      add_exp(s, dd, c, sh, dh);
      base = nlog;
      wr(8'h30, 32'h100);
      wr(8'h40, cw(1, 1, 0, bc, sh, dh));
      wait_stat("R7 random run");
      wait_log(base + c/4);
      wr(8'h40, cw(0, 0, 1, bc, sh, dh));
      chk("R9 random write count", 32'(nlog - base), 32'(c/4));
      cmp_log(base, c/4, "R3 random transfer");
      rd(8'h70, d);
      chk("R7 random current descriptor", d, 32'h110);
      wr(8'hA0, 32'h0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule